// File: doc/BRIEF.md
# 8-bit Accumulator ALU With Condition Flags

This block is the purely combinational arithmetic and logic stage of an accumulator-style processor core. Each cycle it takes the accumulator, a second operand, the current flag byte and an operation code. It returns a result byte, an updated flag byte and a strobe that tells the register file whether the result should be written back.

The supported operations are:
- two-operand arithmetic: add, add with carry, subtract, subtract with carry, and compare;
- bitwise logic: AND, OR and XOR;
- single-operand increment and decrement.

Increment and decrement act on the second operand input rather than on the accumulator, so the surrounding core can aim them at any register. Compare produces the same flags as subtract but never asks for a write. One flag bit has two meanings that depend on the operation: for arithmetic it reports signed overflow, and for logic it reports even parity of the result.

The data path width is a parameter with a default of 8. The flag byte is always 8 bits wide.

Top module: `alu8_top`

## Requirements
- R1: Add (opSel 0) and add-with-carry (opSel 1) give resultOut = (accIn + srcIn + cin) mod 256. For opSel 1, cin is flagsIn bit 0; for opSel 0, cin is 0. Carry (flagsOut bit 0) is the ninth bit of the sum.
- R2: Subtract (opSel 2) and subtract-with-carry (opSel 3) give resultOut = (accIn - srcIn - cin) mod 256, with cin taken as in R1. Carry is set when a borrow occurs. The subtract flag (flagsOut bit 1) is 1.
- R3: For opSel 0 to 3 and 7, flagsOut bit 2 is the two's-complement signed overflow of the operation.
- R4: For opSel 0 to 3 and 7, the half flag (flagsOut bit 4) is set on a carry out of bit 3 (add) or a borrow into bit 4 (subtract), with cin included.
- R5: Compare (opSel 7) sets every flag exactly as subtract (opSel 2) does, and resultWe is 0.
- R6: The logic operations are AND (opSel 4), XOR (opSel 5) and OR (opSel 6). Each one clears carry and the subtract flag. The half flag is 1 for AND and 0 for XOR and OR. flagsOut bit 2 is 1 when the result has an even number of ones.
- R7: Increment (opSel 8) gives resultOut = srcIn + 1 mod 256 and keeps carry from flagsIn. It clears the subtract flag. Overflow is set exactly when the result is 0x80, and the half flag is set exactly when the result's low nibble is 0.
- R8: Decrement (opSel 9) gives resultOut = srcIn - 1 mod 256 and keeps carry from flagsIn. It sets the subtract flag. Overflow is set exactly when the result is 0x7F, and the half flag is set exactly when the result's low nibble is 0xF.
- R9: For every assigned opcode (0 to 9), sign (flagsOut bit 7) equals resultOut bit 7, and zero (flagsOut bit 6) is set exactly when resultOut is 0.
- R10: flagsOut bits 5 and 3 always equal the same bits of flagsIn.
- R11: Unassigned opcodes (10 to 15) give flagsOut = flagsIn and resultWe = 0.
- R12: resultWe is 1 for opSel 0 to 6, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accIn | input | 8 | Accumulator value |
| srcIn | input | 8 | Second operand; the target value for increment and decrement |
| flagsIn | input | 8 | Current flag byte |
| opSel | input | 4 | Operation code |
| resultOut | output | 8 | Operation result |
| flagsOut | output | 8 | Updated flag byte |
| resultWe | output | 1 | Request to write resultOut back |

## Verification
The hardest cases are the signed-overflow and half-carry corners that the incoming carry alone pushes over the edge. For example, adding 0x7F and 0x00 with carry set, or subtracting 0x00 from 0x80 with borrow set, changes the overflow or half flag only because of cin. A random walk reaches these rarely. The stimulus therefore sweeps every accumulator and operand pair with carry-in both clear and set for each two-operand code. Increment and decrement are swept over every operand and every incoming flag byte, so that the kept carry and the copied spare bits are seen in all combinations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_H  = 4;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logicSel_e;

  typedef struct packed {
    logic      valid;
    logic      arith;
    logic      subtract;
    logic      useCarry;
    logic      incDec;
    logic      writeRes;
    logicSel_e logicSel;
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{valid: 1'b0, arith: 1'b0, subtract: 1'b0, useCarry: 1'b0,
             incDec: 1'b0, writeRes: 1'b0, logicSel: LG_AND};
    case (opSel)
      OP_ADD: begin ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.writeRes = 1'b1; end
      OP_ADC: begin ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.useCarry = 1'b1; ctrl.writeRes = 1'b1; end
      OP_SUB: begin ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.subtract = 1'b1; ctrl.writeRes = 1'b1; end
      OP_SBC: begin
        ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.subtract = 1'b1;
        ctrl.useCarry = 1'b1; ctrl.writeRes = 1'b1;
      end
      OP_CMP: begin ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.subtract = 1'b1; end
      OP_AND: begin ctrl.valid = 1'b1; ctrl.logicSel = LG_AND; ctrl.writeRes = 1'b1; end
      OP_XOR: begin ctrl.valid = 1'b1; ctrl.logicSel = LG_XOR; ctrl.writeRes = 1'b1; end
      OP_OR:  begin ctrl.valid = 1'b1; ctrl.logicSel = LG_OR;  ctrl.writeRes = 1'b1; end
      OP_INC: begin ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.incDec = 1'b1; ctrl.writeRes = 1'b1; end
      OP_DEC: begin
        ctrl.valid = 1'b1; ctrl.arith = 1'b1; ctrl.incDec = 1'b1;
        ctrl.subtract = 1'b1; ctrl.writeRes = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_dpath.sv
module alu8_dpath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [7:0]        flagsIn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] resultOut,
  output logic [7:0]        flagsOut
);

  localparam int MSB      = DATA_W - 1;
  localparam int HALF_BIT = DATA_W / 2;

  logic [DATA_W-1:0] opA, opB, arithRes, logicRes, halfVec;
  logic [DATA_W:0]   sumW;
  logic              carryIn, carryOut, halfOut, ovfOut, signDiff;

  // Increment and decrement reuse the adder with the operand as A and a constant one as B.
  assign opA     = ctrl.incDec ? srcIn : accIn;
  assign opB     = ctrl.incDec ? {{(DATA_W-1){1'b0}}, 1'b1} : srcIn;
  assign carryIn = ctrl.useCarry & flagsIn[FLG_C];

  always_comb begin
    if (ctrl.subtract)
      sumW = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, carryIn};
    else
      sumW = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  end

  assign arithRes = sumW[MSB:0];
  assign carryOut = sumW[DATA_W];
  assign halfVec  = opA ^ opB ^ arithRes;
  assign halfOut  = halfVec[HALF_BIT];
  assign signDiff = opA[MSB] ^ opB[MSB];
  assign ovfOut   = (ctrl.subtract ? signDiff : ~signDiff) & (arithRes[MSB] ^ opA[MSB]);

  always_comb begin
    case (ctrl.logicSel)
      LG_AND:  logicRes = accIn & srcIn;
      LG_XOR:  logicRes = accIn ^ srcIn;
      default: logicRes = accIn | srcIn;
    endcase
  end

  always_comb begin
    if (!ctrl.valid)      resultOut = accIn;
    else if (ctrl.arith)  resultOut = arithRes;
    else                  resultOut = logicRes;
  end

  always_comb begin
    flagsOut = flagsIn;
    if (ctrl.valid) begin
      flagsOut[FLG_S] = resultOut[MSB];
      flagsOut[FLG_Z] = (resultOut == '0);
      if (ctrl.arith) begin
        flagsOut[FLG_H]  = halfOut;
        flagsOut[FLG_PV] = ovfOut;
        flagsOut[FLG_N]  = ctrl.subtract;
        flagsOut[FLG_C]  = ctrl.incDec ? flagsIn[FLG_C] : carryOut;
      end else begin
        flagsOut[FLG_H]  = (ctrl.logicSel == LG_AND);
        flagsOut[FLG_PV] = ~^resultOut;
        flagsOut[FLG_N]  = 1'b0;
        flagsOut[FLG_C]  = 1'b0;
      end
    end
  end

  always_comb begin
    if (ctrl.incDec && !ctrl.subtract) begin
      p_inc_ovf_r7: assert (flagsOut[FLG_PV] == (resultOut == {1'b1, {MSB{1'b0}}}))
        else $error("inc overflow rule broken");
      p_inc_half_r7: assert (flagsOut[FLG_H] == (resultOut[HALF_BIT-1:0] == '0))
        else $error("inc half rule broken");
      p_inc_keepc_r7: assert (flagsOut[FLG_C] == flagsIn[FLG_C])
        else $error("inc changed carry");
    end
    if (ctrl.incDec && ctrl.subtract) begin
      p_dec_ovf_r8: assert (flagsOut[FLG_PV] == (resultOut == {1'b0, {MSB{1'b1}}}))
        else $error("dec overflow rule broken");
      p_dec_half_r8: assert (flagsOut[FLG_H] == (resultOut[HALF_BIT-1:0] == '1))
        else $error("dec half rule broken");
      p_dec_keepc_r8: assert (flagsOut[FLG_C] == flagsIn[FLG_C])
        else $error("dec changed carry");
    end
    if (ctrl.valid && !ctrl.arith) begin
      p_logic_clear_r6: assert (!flagsOut[FLG_C] && !flagsOut[FLG_N])
        else $error("logic op left carry or subtract set");
    end
    if (ctrl.valid) begin
      p_zero_r9: assert (flagsOut[FLG_Z] == (resultOut == '0))
        else $error("zero flag mismatch");
    end else begin
      p_hold_flags_r11: assert (flagsOut == flagsIn)
        else $error("unassigned opcode changed flags");
    end
    p_spare_bits_r10: assert (flagsOut[5] == flagsIn[5] && flagsOut[3] == flagsIn[3])
      else $error("spare flag bits changed");
  end

endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [7:0]        flagsIn,
  input  logic [3:0]        opSel,
  output logic [DATA_W-1:0] resultOut,
  output logic [7:0]        flagsOut,
  output logic              resultWe
);

  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu8_dpath #(.DATA_W(DATA_W)) u_dpath (
    .accIn     (accIn),
    .srcIn     (srcIn),
    .flagsIn   (flagsIn),
    .ctrl      (ctrl),
    .resultOut (resultOut),
    .flagsOut  (flagsOut)
  );

  assign resultWe = ctrl.writeRes;

  always_comb begin
    if (opSel == OP_CMP) begin
      p_cmp_nowrite_r5: assert (!resultWe) else $error("compare requested a write");
    end
    if (opSel > 4'd9) begin
      p_unassigned_nowrite_r11: assert (!resultWe) else $error("unassigned opcode wrote");
    end
  end

endmodule

// File: tb/alu8_top_test.sv
`timescale 1ns/1ps
module alu8_top_test;

  logic       clk = 1'b0;
  logic [7:0] accIn, srcIn, flagsIn, resultOut, flagsOut;
  logic [3:0] opSel;
  logic       resultWe;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_top uut (
    .accIn(accIn), .srcIn(srcIn), .flagsIn(flagsIn), .opSel(opSel),
    .resultOut(resultOut), .flagsOut(flagsOut), .resultWe(resultWe)
  );

  task automatic chk(input string tag, input int act, input int exp, input int op, input int a, input int b);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h actual=%0h expected=%0h",
               tag, op, a, b, flagsIn, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // Apply one stimulus, compute expectations arithmetically, compare fields.
  task automatic run(input int op, input int a, input int b, input int f);
    int cin, res, raw, sa, sb, sr, hc, ov, cy, nf, we;
    string tr, th;
    accIn = 8'(a); srcIn = 8'(b); flagsIn = 8'(f); opSel = 4'(op);
    #0.05;
    cin = ((op == 1) || (op == 3)) ? (f & 1) : 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    we = 1; hc = 0; ov = 0; cy = 0; nf = 0; res = 0;
    tr = "R1"; th = "R4";
    case (op)
      0, 1: begin
        raw = a + b + cin; res = raw & 255; cy = raw > 255;
        sr = sa + sb + cin; ov = (sr > 127) || (sr < -128);
        hc = ((a & 15) + (b & 15) + cin) > 15;
      end
      2, 3, 7: begin
        raw = a - b - cin; res = raw & 255; cy = raw < 0; nf = 1;
        sr = sa - sb - cin; ov = (sr > 127) || (sr < -128);
        hc = ((a & 15) - (b & 15) - cin) < 0;
        tr = (op == 7) ? "R5" : "R2";
        if (op == 7) we = 0;
      end
      4, 5, 6: begin
        res = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        hc = (op == 4); ov = (ones(res) % 2) == 0;
        tr = "R6"; th = "R6";
      end
      8: begin
        res = (b + 1) & 255; cy = f & 1; ov = (res == 128); hc = (res & 15) == 0;
        tr = "R7"; th = "R7";
      end
      9: begin
        res = (b + 255) & 255; cy = f & 1; nf = 1; ov = (res == 127); hc = (res & 15) == 15;
        tr = "R8"; th = "R8";
      end
      default: we = 0;
    endcase
    if (op <= 9) begin
      if (op != 7) chk(tr, resultOut, res, op, a, b);
      chk({tr, " carry"}, flagsOut[0], cy, op, a, b);
      chk({tr, " subtract flag"}, flagsOut[1], nf, op, a, b);
      chk({th, " half"}, flagsOut[4], hc, op, a, b);
      chk((op >= 4 && op <= 6) ? "R6 parity" : (op >= 8) ? {tr, " overflow"} : "R3 overflow",
          flagsOut[2], ov, op, a, b);
      chk("R9 sign", flagsOut[7], (res >> 7) & 1, op, a, b);
      chk("R9 zero", flagsOut[6], res == 0, op, a, b);
      chk("R10 spare bits", {flagsOut[5], flagsOut[3]}, {f[5], f[3]}, op, a, b);
      chk((op == 7) ? "R5 no write" : "R12 write", resultWe, we, op, a, b);
    end else begin
      chk("R11 flags held", flagsOut, f, op, a, b);
      chk("R11 no write", resultWe, 0, op, a, b);
    end
    #0.05;
  endtask

  initial begin
    // First check: all-zero inputs decode as add of zero; expect result 0 with only Z set
    accIn = 0; srcIn = 0; flagsIn = 0; opSel = 0;
    #1;
    chk("R9 zero at start", flagsOut, 8'h40, 0, 0, 0);
    chk("R1 result at start", resultOut, 0, 0, 0, 0);
    // Two-operand codes: every a/b pair with carry-in clear and set
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          for (int c = 0; c < 2; c++)
            run(op, a, b, ((a ^ ((b << 4) | (b >> 4))) & 8'hFE) | c);
    // Increment / decrement: every operand with every incoming flag byte
    for (int op = 8; op < 10; op++)
      for (int b = 0; b < 256; b++)
        for (int f = 0; f < 256; f++)
          run(op, (b * 37) & 255, b, f);
    // Unassigned codes
    for (int op = 10; op < 16; op++)
      for (int f = 0; f < 256; f++)
        run(op, f ^ 8'h5A, 255 - f, f);
    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule